// File: doc/BRIEF.md
# Multi-Level Priority Egress Scheduler

This block decides, for one egress port, which of up to eight packet queues sends next. Each queue has one of five priority tiers: strict-high, high, medium-high, medium-low and low. Whenever the downstream transmitter is ready, the scheduler looks at the highest tier that holds a non-empty queue and grants one queue in that tier. Queues in the same tier take turns in round-robin order. A strict-high queue with backlog always wins, and no fairness limit applies. Packet payloads stay elsewhere. The block tracks only how many packets each queue holds.

On the ingress side, an enqueue request carries a queue id, chosen upstream from the packet's forwarding class, and a loss-priority bit. An admission stage accepts or refuses each request against the queue's current occupancy. Each queue uses one of two drop policies. Under tail drop, only the queue limit applies. Under early discard, packets with high loss priority are refused at a lower threshold.

A two-state controller tracks whether any packet is held. In `SCH_IDLE` nothing is queued and no grant is possible. The transition *wake* (an accepted enqueue) moves it to `SCH_BUSY`. In `SCH_BUSY` at least one queue is non-empty. The transition *drain* (the last held packet is granted with no accepted enqueue in the same cycle) returns it to `SCH_IDLE`. In every other case the state is held (*stay*).

Top module: `egress_prio_sched`

## Requirements
- R1: After reset every queue occupancy is zero, and no grant is issued even with `tx_ready` high.
- R2: At most one grant is issued per cycle. `grant_valid` is high exactly when `tx_ready` is high and at least one queue is non-empty.
- R3: Tier codes are 0 strict-high, 1 high, 2 medium-high, 3 medium-low and 4 low. Codes 5 to 7 act as low. The granted queue always belongs to the highest-priority (numerically smallest) tier that holds a non-empty queue.
- R4: Each tier has a pointer that starts at 0 after reset. Within the chosen tier, the grant goes to the first non-empty queue of that tier at or after the pointer, scanning upward and wrapping past NQ-1. After a grant, that tier's pointer becomes the granted id plus one, modulo NQ. Pointers of tiers that were not served do not move.
- R5: With drop mode bit 0 (tail drop), an enqueue is accepted exactly when occupancy is below the queue limit, whatever its loss priority.
- R6: With drop mode bit 1 (early discard), a request with `enq_lp`=1 is accepted only when occupancy is below both the threshold and the limit. A request with `enq_lp`=0 is accepted when occupancy is below the limit.
- R7: Occupancy rises by one on an accepted enqueue and falls by one on a grant. When both hit the same queue in one cycle, the count stays the same. The new count is visible after the next clock edge.
- R8: While `enq_valid` is high, exactly one of `enq_accept` and `enq_drop` is high in the same cycle. Both are low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Enqueue request present |
| enq_qid | input | QW | Target queue of the request |
| enq_lp | input | 1 | Loss priority of the request (1 = high) |
| enq_accept | output | 1 | Request admitted this cycle |
| enq_drop | output | 1 | Request refused this cycle |
| cfg_level | input | NQ*3 | Tier code per queue, queue q at bits [3q+2:3q] |
| cfg_early | input | NQ | Drop mode per queue (0 tail drop, 1 early discard) |
| cfg_limit | input | NQ*CNT_W | Occupancy limit per queue |
| cfg_thresh | input | NQ*CNT_W | Early-discard threshold per queue |
| occ | output | NQ*CNT_W | Occupancy per queue, queue q at bits [CNT_W*q +: CNT_W] |
| tx_ready | input | 1 | Downstream can take a packet this cycle |
| grant_valid | output | 1 | A queue is granted this cycle |
| grant_qid | output | QW | Granted queue id |

## Verification
The admission result and the grant are due in the same cycle as the request and `tx_ready`, because both are computed from the registered counts. Occupancy and the round-robin pointers change only at the following rising edge. The bench drives each cycle's inputs just after the falling edge and reads the outputs one nanosecond later. It compares them with a behavioural model whose state has not yet taken that cycle's update, and only then advances the model. The occupancy it reads is therefore the result of the previous cycle's stimulus.

// File: rtl/sched_pkg.sv
package sched_pkg;

    localparam int NUM_LVL = 5;
    localparam int LVL_W   = 3;

    typedef enum logic [LVL_W-1:0] {
        LVL_SH = 3'd0,
        LVL_HI = 3'd1,
        LVL_MH = 3'd2,
        LVL_ML = 3'd3,
        LVL_LO = 3'd4
    } lvl_e;

    typedef enum logic {
        SCH_IDLE = 1'b0,
        SCH_BUSY = 1'b1
    } sch_state_e;

    // Codes outside the five tiers fall into the lowest tier.
    function automatic lvl_e clamp_lvl(input logic [LVL_W-1:0] code);
        if (code > 3'd4) return LVL_LO;
        return lvl_e'(code);
    endfunction

endpackage

// File: rtl/sched_admit.sv
module sched_admit #(
    parameter  int NQ    = 8,
    parameter  int CNT_W = 8,
    localparam int QW    = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic                  enq_valid,
    input  logic [QW-1:0]         enq_qid,
    input  logic                  enq_lp,
    input  logic [NQ-1:0]         cfg_early,
    input  logic [NQ*CNT_W-1:0]   cfg_limit,
    input  logic [NQ*CNT_W-1:0]   cfg_thresh,
    input  logic [NQ*CNT_W-1:0]   occ_flat,
    output logic                  accept,
    output logic                  drop
);
    logic [CNT_W-1:0] cur, lim, thr;
    logic             early, in_range, room;

    always_comb begin
        cur      = '0;
        lim      = '0;
        thr      = '0;
        early    = 1'b0;
        in_range = 1'b0;
        for (int q = 0; q < NQ; q++) begin
            if (enq_qid == QW'(q)) begin
                cur      = occ_flat[q*CNT_W +: CNT_W];
                lim      = cfg_limit[q*CNT_W +: CNT_W];
                thr      = cfg_thresh[q*CNT_W +: CNT_W];
                early    = cfg_early[q];
                in_range = 1'b1;
            end
        end
        room = (cur < lim);
        if (early && enq_lp) room = room && (cur < thr);
        accept = enq_valid && in_range && room;
        drop   = enq_valid && !accept;
    end
endmodule

// File: rtl/sched_occ_bank.sv
module sched_occ_bank #(
    parameter  int NQ    = 8,
    parameter  int CNT_W = 8,
    localparam int QW    = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                inc_valid,
    input  logic [QW-1:0]       inc_qid,
    input  logic                dec_valid,
    input  logic [QW-1:0]       dec_qid,
    output logic [NQ*CNT_W-1:0] occ_flat,
    output logic [NQ-1:0]       nonempty
);
    for (genvar q = 0; q < NQ; q++) begin : g_cnt
        logic [CNT_W-1:0] cnt_q;
        logic             inc_hit, dec_hit;

        assign inc_hit = inc_valid && (inc_qid == QW'(q));
        assign dec_hit = dec_valid && (dec_qid == QW'(q));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else begin
                unique case ({inc_hit, dec_hit})
                    2'b10:   cnt_q <= cnt_q + 1'b1;
                    2'b01:   cnt_q <= cnt_q - 1'b1;
                    default: cnt_q <= cnt_q;
                endcase
            end
        end

        assign occ_flat[q*CNT_W +: CNT_W] = cnt_q;
        assign nonempty[q]                = (cnt_q != '0);
    end
endmodule

// File: rtl/sched_level_rr.sv
module sched_level_rr #(
    parameter  int NQ = 8,
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NQ-1:0] req,
    input  logic          advance,
    output logic          any,
    output logic [QW-1:0] pick
);
    logic [QW-1:0] ptr_q;

    // The downward scan lets the smallest offset from the pointer win.
    always_comb begin
        pick = '0;
        for (int i = NQ - 1; i >= 0; i--) begin
            if (req[(int'(ptr_q) + i) % NQ]) pick = QW'((int'(ptr_q) + i) % NQ);
        end
        any = |req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ptr_q <= '0;
        else if (advance) ptr_q <= QW'((int'(pick) + 1) % NQ);
    end
endmodule

// File: rtl/egress_prio_sched.sv
module egress_prio_sched
    import sched_pkg::*;
#(
    parameter  int NQ    = 8,
    parameter  int CNT_W = 8,
    localparam int QW    = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enq_valid,
    input  logic [QW-1:0]        enq_qid,
    input  logic                 enq_lp,
    output logic                 enq_accept,
    output logic                 enq_drop,
    input  logic [NQ*LVL_W-1:0]  cfg_level,
    input  logic [NQ-1:0]        cfg_early,
    input  logic [NQ*CNT_W-1:0]  cfg_limit,
    input  logic [NQ*CNT_W-1:0]  cfg_thresh,
    output logic [NQ*CNT_W-1:0]  occ,
    input  logic                 tx_ready,
    output logic                 grant_valid,
    output logic [QW-1:0]        grant_qid
);
    sch_state_e       state_q, state_d;
    logic [NQ-1:0]    nonempty;
    logic [NQ-1:0]    lvl_req  [NUM_LVL];
    logic             lvl_any  [NUM_LVL];
    logic [QW-1:0]    lvl_pick [NUM_LVL];
    logic [NUM_LVL-1:0] lvl_adv;
    int unsigned      sel_lvl;
    logic [CNT_W-1:0] grant_cnt;
    logic             last_pkt;

    sched_admit #(.NQ(NQ), .CNT_W(CNT_W)) admit_i (
        .enq_valid (enq_valid),
        .enq_qid   (enq_qid),
        .enq_lp    (enq_lp),
        .cfg_early (cfg_early),
        .cfg_limit (cfg_limit),
        .cfg_thresh(cfg_thresh),
        .occ_flat  (occ),
        .accept    (enq_accept),
        .drop      (enq_drop)
    );

    sched_occ_bank #(.NQ(NQ), .CNT_W(CNT_W)) occ_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_valid(enq_accept),
        .inc_qid  (enq_qid),
        .dec_valid(grant_valid),
        .dec_qid  (grant_qid),
        .occ_flat (occ),
        .nonempty (nonempty)
    );

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        for (genvar q = 0; q < NQ; q++) begin : g_req
            assign lvl_req[l][q] = nonempty[q] &&
                (clamp_lvl(cfg_level[q*LVL_W +: LVL_W]) == lvl_e'(l));
        end
        assign lvl_adv[l] = grant_valid && (sel_lvl == l);

        sched_level_rr #(.NQ(NQ)) rr_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .req    (lvl_req[l]),
            .advance(lvl_adv[l]),
            .any    (lvl_any[l]),
            .pick   (lvl_pick[l])
        );
    end

    // The highest tier with backlog takes the grant.
    always_comb begin
        sel_lvl = NUM_LVL - 1;
        for (int l = NUM_LVL - 1; l >= 0; l--) begin
            if (lvl_any[l]) sel_lvl = l;
        end
    end

    always_comb begin
        grant_cnt = '0;
        for (int q = 0; q < NQ; q++) begin
            if (grant_qid == QW'(q)) grant_cnt = occ[q*CNT_W +: CNT_W];
        end
        last_pkt = ($countones(nonempty) == 1) && (grant_cnt == CNT_W'(1));
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SCH_IDLE;
        else        state_q <= state_d;
    end

    // Next state: wake, drain or stay.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCH_IDLE: if (enq_accept) state_d = SCH_BUSY;
            SCH_BUSY: if (grant_valid && last_pkt && !enq_accept) state_d = SCH_IDLE;
            default:  state_d = SCH_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        grant_valid = 1'b0;
        grant_qid   = lvl_pick[sel_lvl];
        unique case (state_q)
            SCH_IDLE: grant_valid = 1'b0;
            SCH_BUSY: grant_valid = tx_ready;
            default:  grant_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/sched_checker.sv
module sched_checker #(
    parameter  int NQ    = 8,
    parameter  int CNT_W = 8,
    localparam int QW    = (NQ > 1) ? $clog2(NQ) : 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                enq_valid,
    input logic [QW-1:0]       enq_qid,
    input logic                enq_lp,
    input logic                enq_accept,
    input logic                enq_drop,
    input logic [NQ*3-1:0]     cfg_level,
    input logic [NQ-1:0]       cfg_early,
    input logic [NQ*CNT_W-1:0] cfg_limit,
    input logic [NQ*CNT_W-1:0] cfg_thresh,
    input logic [NQ*CNT_W-1:0] occ,
    input logic                tx_ready,
    input logic                grant_valid,
    input logic [QW-1:0]       grant_qid
);
    logic             sh_busy, any_busy;
    logic [CNT_W-1:0] g_cnt, e_cnt, e_lim, e_thr;
    logic [2:0]       g_lvl;
    logic             e_early;

    always_comb begin
        sh_busy  = 1'b0;
        any_busy = 1'b0;
        g_cnt = '0; g_lvl = '0; e_cnt = '0; e_lim = '0; e_thr = '0; e_early = 1'b0;
        for (int q = 0; q < NQ; q++) begin
            if (occ[q*CNT_W +: CNT_W] != '0) begin
                any_busy = 1'b1;
                if (cfg_level[q*3 +: 3] == 3'd0) sh_busy = 1'b1;
            end
            if (grant_qid == QW'(q)) begin
                g_cnt = occ[q*CNT_W +: CNT_W];
                g_lvl = cfg_level[q*3 +: 3];
            end
            if (enq_qid == QW'(q)) begin
                e_cnt   = occ[q*CNT_W +: CNT_W];
                e_lim   = cfg_limit[q*CNT_W +: CNT_W];
                e_thr   = cfg_thresh[q*CNT_W +: CNT_W];
                e_early = cfg_early[q];
            end
        end
    end

    // Expected count of a granted queue after the edge.
    logic             chk_q;
    logic [QW-1:0]    chk_qid;
    logic [CNT_W-1:0] chk_val;
    logic [CNT_W-1:0] chk_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_q   <= 1'b0;
            chk_qid <= '0;
            chk_val <= '0;
        end else begin
            chk_q   <= grant_valid && !(enq_accept && enq_qid == grant_qid);
            chk_qid <= grant_qid;
            chk_val <= g_cnt - 1'b1;
        end
    end

    always_comb begin
        chk_now = '0;
        for (int q = 0; q < NQ; q++) begin
            if (chk_qid == QW'(q)) chk_now = occ[q*CNT_W +: CNT_W];
        end
    end

    assert_grant_needs_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> tx_ready);
    assert_grant_needs_backlog_R2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (any_busy && g_cnt != '0));
    assert_ready_backlog_grants_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && any_busy) |-> grant_valid);
    assert_strict_high_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && sh_busy) |-> (g_lvl == 3'd0));
    assert_below_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        enq_accept |-> (e_cnt < e_lim));
    assert_early_threshold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_accept && enq_lp && e_early) |-> (e_cnt < e_thr));
    assert_grant_decrements_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chk_q |-> (chk_now == chk_val));
    assert_accept_drop_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_accept || enq_drop) |-> (enq_valid && (enq_accept != enq_drop)));
endmodule

bind egress_prio_sched sched_checker #(.NQ(NQ), .CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .enq_valid  (enq_valid),
    .enq_qid    (enq_qid),
    .enq_lp     (enq_lp),
    .enq_accept (enq_accept),
    .enq_drop   (enq_drop),
    .cfg_level  (cfg_level),
    .cfg_early  (cfg_early),
    .cfg_limit  (cfg_limit),
    .cfg_thresh (cfg_thresh),
    .occ        (occ),
    .tx_ready   (tx_ready),
    .grant_valid(grant_valid),
    .grant_qid  (grant_qid)
);

// File: tb/egress_prio_sched_tb_top.sv
module egress_prio_sched_tb_top;
    localparam int NQ    = 8;
    localparam int CNT_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              enq_valid = 1'b0;
    logic [2:0]        enq_qid = '0;
    logic              enq_lp = 1'b0;
    logic              enq_accept, enq_drop;
    logic [NQ*3-1:0]   cfg_level;
    logic [NQ-1:0]     cfg_early;
    logic [NQ*CNT_W-1:0] cfg_limit, cfg_thresh, occ;
    logic              tx_ready = 1'b0;
    logic              grant_valid;
    logic [2:0]        grant_qid;

    always #10 clk = ~clk;

    egress_prio_sched #(.NQ(NQ), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_qid(enq_qid), .enq_lp(enq_lp),
        .enq_accept(enq_accept), .enq_drop(enq_drop),
        .cfg_level(cfg_level), .cfg_early(cfg_early),
        .cfg_limit(cfg_limit), .cfg_thresh(cfg_thresh),
        .occ(occ), .tx_ready(tx_ready),
        .grant_valid(grant_valid), .grant_qid(grant_qid)
    );

    int nvec = 0;
    int nfail = 0;
    bit done = 1'b0;

    int m_lvl[NQ]   = '{0, 1, 1, 2, 2, 2, 4, 7};
    int m_early[NQ] = '{0, 0, 0, 0, 1, 1, 1, 1};
    int m_lim[NQ]   = '{4, 3, 4, 4, 4, 5, 4, 4};
    int m_thr[NQ]   = '{2, 2, 2, 2, 2, 3, 1, 2};
    int m_cnt[NQ];
    int m_ptr[5];

    initial begin
        for (int q = 0; q < NQ; q++) begin
            cfg_level[q*3 +: 3]          = 3'(m_lvl[q]);
            cfg_early[q]                 = m_early[q][0];
            cfg_limit[q*CNT_W +: CNT_W]  = CNT_W'(m_lim[q]);
            cfg_thresh[q*CNT_W +: CNT_W] = CNT_W'(m_thr[q]);
            m_cnt[q] = 0;
        end
        for (int l = 0; l < 5; l++) m_ptr[l] = 0;
    end

    task automatic chk(input string tag, input int got, input int exp);
        nvec++;
        if (got != exp) begin
            nfail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int eff_lvl(input int q);
        return (m_lvl[q] > 4) ? 4 : m_lvl[q];
    endfunction

    task automatic step(input bit v, input int q, input bit lp, input bit rdy);
        int  best, gq;
        bit  acc, gv;
        @(negedge clk);
        enq_valid = v; enq_qid = 3'(q); enq_lp = lp; tx_ready = rdy;
        #1;
        for (int k = 0; k < NQ; k++)
            chk($sformatf("R7 occ q%0d", k), int'(occ[k*CNT_W +: CNT_W]), m_cnt[k]);
        // admission
        if (m_early[q] != 0 && lp) acc = v && (m_cnt[q] < m_thr[q]) && (m_cnt[q] < m_lim[q]);
        else                       acc = v && (m_cnt[q] < m_lim[q]);
        chk((m_early[q] != 0) ? "R6 accept" : "R5 accept", int'(enq_accept), int'(acc));
        chk("R8 drop", int'(enq_drop), int'(v && !acc));
        // grant
        best = 5;
        for (int k = 0; k < NQ; k++)
            if (m_cnt[k] > 0 && eff_lvl(k) < best) best = eff_lvl(k);
        gv = rdy && (best < 5);
        gq = 0;
        chk("R2 grant_valid", int'(grant_valid), int'(gv));
        if (gv) begin
            for (int i = NQ - 1; i >= 0; i--) begin
                if (m_cnt[(m_ptr[best] + i) % NQ] > 0 && eff_lvl((m_ptr[best] + i) % NQ) == best)
                    gq = (m_ptr[best] + i) % NQ;
            end
            chk("R3 R4 grant_qid", int'(grant_qid), gq);
            m_ptr[best] = (gq + 1) % NQ;
            m_cnt[gq]--;
        end
        if (acc) m_cnt[q]++;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        tx_ready = 1'b1;
        #1;
        for (int k = 0; k < NQ; k++)
            chk($sformatf("R1 reset occ q%0d", k), int'(occ[k*CNT_W +: CNT_W]), 0);
        chk("R1 reset no grant", int'(grant_valid), 0);
        rst_n = 1'b1;
        step(0, 0, 0, 1);
        chk("R1 idle no grant", int'(grant_valid), 0);

        // Fill with transmitter stalled: tail drop on q0, early discard on q4.
        for (int i = 0; i < 5; i++) step(1, 0, 1, 0);
        for (int i = 0; i < 3; i++) step(1, 4, 1, 0);
        for (int i = 0; i < 3; i++) step(1, 4, 0, 0);
        for (int i = 0; i < 2; i++) step(1, 6, 1, 0);
        for (int i = 0; i < 2; i++) step(1, 6, 0, 0);
        for (int k = 1; k < NQ; k++) begin
            step(1, k, 0, 0);
            step(1, k, 0, 0);
        end
        step(0, 0, 0, 0);
        // Drain: strict-high first, then round-robin per tier.
        for (int i = 0; i < 30; i++) step(0, 0, 0, 1);
        // Same-queue enqueue and grant in one cycle.
        step(1, 3, 0, 0);
        for (int i = 0; i < 6; i++) step(1, 3, 0, 1);
        for (int i = 0; i < 4; i++) step(0, 0, 0, 1);
        // Mixed traffic.
        for (int i = 0; i < 4000; i++)
            step(($urandom % 4) != 0, $urandom % NQ, $urandom % 2, ($urandom % 3) == 0);
        for (int i = 0; i < 60; i++) step(0, 0, 0, 1);
        for (int k = 0; k < NQ; k++)
            chk($sformatf("R7 drained q%0d", k), int'(occ[k*CNT_W +: CNT_W]), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end
endmodule